// File: doc/BRIEF.md
# Port-Pair Bypass and Watchdog Mode Controller

This block holds the operating state of one pair of network ports. The pair is in one of three states. In normal state the two ports work as separate host interfaces. In bypass state the two network ports are cross-connected to each other and the host side is isolated. In disconnect state transmit toward both ports is cut, so that the link partners see no link. Software sets the state directly through a small write-only register port. A watchdog can also set it: host software must refresh the watchdog before a timeout of 2^p ticks. The tick is nominally 100 ms, and the exponent p runs from 0 to 15.

Two capability bits can forbid bypass or disconnect. A forbidden state is never entered, whether by a command, by a timeout or by a default, so the port pair then acts as an ordinary network card. A retained register holds the two capability bits and two defaults. The power-up default may be any of the three states. The power-off default may be only bypass or normal. An active-low power-good input models the loss of supply. The outputs are registered relay controls and a two-colour status LED. The LED is off in normal, green in bypass and yellow in disconnect.

Top module: `bypass_wdt_ctrl`

## Requirements
- R1: After reset, with the retained register at its initial value (both capabilities on, power-up state normal, power-off state bypass), every output is low and `mode_o` reads 0 (normal).
- R2: A write to address 0 sets the state from data bits [1:0]: 0 for normal, 1 for bypass and 2 for disconnect. The code 3 is ignored and leaves the state unchanged.
- R3: In bypass state, `relay_cross`, `host_iso` and `led_green` are high, and `tx_cut` and `led_yellow` are low. Green and yellow are never high together.
- R4: In disconnect state, `tx_cut` and `led_yellow` are high, and `relay_cross`, `host_iso` and `led_green` are low. In normal state every output is low.
- R5: Address 2 is the retained register: bit 0 enables bypass, bit 1 enables disconnect, bits [3:2] give the power-up state and bit 4 selects bypass (1) or normal (0) as the power-off state. A command for a state whose capability is off is ignored.
- R6: When the capability of the current state is turned off, the block falls back to normal.
- R7: Address 1 holds the exponent p in bits [3:0], the watchdog enable in bit 4 and the failure state in bit 5 (0 for bypass, 1 for disconnect). While the watchdog is enabled it expires on exactly the 2^p-th tick after its last restart.
- R8: On expiry the block enters the failure state if that capability is on. If the capability is off, the state is unchanged.
- R9: After an expiry the failure state is held. A write to address 3 with bit 0 clear does not change the state. A write to address 3 with bit 0 set, or a new write to address 0, changes it.
- R10: A write to address 3 restarts the tick count from zero.
- R11: A write to address 1 reloads the tick count at once, so that the full new timeout applies.
- R12: While `pwr_good` is low, the outputs show the power-off state, which is bypass only when bit 4 and the bypass capability are both set. Otherwise they show normal.
- R13: On reset, and while `pwr_good` is low, the state is loaded with the power-up state, or with normal if that state is not permitted. The retained register keeps its value through reset.
- R14: With the watchdog disabled, ticks never cause an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Low models supply loss |
| tick | input | 1 | One-cycle watchdog time-base pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 6 | Register write data |
| mode_o | output | 2 | Effective state: 0 normal, 1 bypass, 2 disconnect |
| relay_cross | output | 1 | Cross-connect the two network ports |
| host_iso | output | 1 | Isolate the host interfaces |
| tx_cut | output | 1 | Cut transmit toward the ports |
| led_green | output | 1 | Status LED green |
| led_yellow | output | 1 | Status LED yellow |

## Verification
A write, tick or power-good change sampled at one clock edge updates the internal state at that edge, and the registered outputs show it at the next edge. A write to the retained register adds one more edge, because the capability bits gate the state only after they are stored. The bench drives inputs on falling edges and waits three full cycles before each comparison, so every result has settled. Timeouts are still counted exactly: each sweep step checks the outputs after 2^p-1 ticks and again after one more tick.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam logic [1:0] MD_NORMAL = 2'd0;
  localparam logic [1:0] MD_BYPASS = 2'd1;
  localparam logic [1:0] MD_DISC   = 2'd2;

  localparam int A_MODE = 0;
  localparam int A_WDT  = 1;
  localparam int A_NV   = 2;
  localparam int A_KICK = 3;

  function automatic logic mode_ok(logic [1:0] m, logic cap_b, logic cap_d);
    case (m)
      MD_NORMAL: mode_ok = 1'b1;
      MD_BYPASS: mode_ok = cap_b;
      MD_DISC:   mode_ok = cap_d;
      default:   mode_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bwd_timer.sv
module bwd_timer #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic             tick,
  input  logic [EXP_W-1:0] exp_p,
  output logic             expire
);
  localparam int CNT_W = 1 << EXP_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last   = (CNT_W'(1) << exp_p) - CNT_W'(1);
  assign expire = run && tick && !clear && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= expire ? '0 : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/bwd_mode.sv
module bwd_mode
  import bwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_mode,
  input  logic       restore,
  input  logic       expire,
  input  logic       fail_disc,
  input  logic       cap_byp,
  input  logic       cap_disc,
  input  logic [1:0] pu_mode,
  output logic [1:0] mode_q
);
  logic [1:0] pu_eff;
  logic [1:0] pick;
  logic [1:0] fail_md;
  logic [1:0] nxt;

  assign pu_eff  = mode_ok(pu_mode, cap_byp, cap_disc) ? pu_mode : MD_NORMAL;
  assign fail_md = fail_disc ? MD_DISC : MD_BYPASS;

  always_comb begin
    pick = mode_q;
    if (cmd_valid) begin
      if (mode_ok(cmd_mode, cap_byp, cap_disc)) pick = cmd_mode;
    end else if (restore) begin
      pick = MD_NORMAL;
    end else if (expire) begin
      if (mode_ok(fail_md, cap_byp, cap_disc)) pick = fail_md;
    end
    nxt = mode_ok(pick, cap_byp, cap_disc) ? pick : MD_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst || !pwr_good) mode_q <= pu_eff;
    else                  mode_q <= nxt;
  end
endmodule

// File: rtl/bwd_drive.sv
module bwd_drive
  import bwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good,
  input  logic [1:0] mode,
  input  logic       po_byp,
  input  logic       cap_byp,
  output logic [1:0] mode_o,
  output logic       relay_cross,
  output logic       host_iso,
  output logic       tx_cut,
  output logic       led_green,
  output logic       led_yellow
);
  logic [1:0] eff;

  assign eff = pwr_good ? mode : ((po_byp && cap_byp) ? MD_BYPASS : MD_NORMAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o      <= MD_NORMAL;
      relay_cross <= 1'b0;
      host_iso    <= 1'b0;
      tx_cut      <= 1'b0;
      led_green   <= 1'b0;
      led_yellow  <= 1'b0;
    end else begin
      mode_o      <= eff;
      relay_cross <= (eff == MD_BYPASS);
      host_iso    <= (eff == MD_BYPASS);
      tx_cut      <= (eff == MD_DISC);
      led_green   <= (eff == MD_BYPASS);
      led_yellow  <= (eff == MD_DISC);
    end
  end
endmodule

// File: rtl/bypass_wdt_ctrl.sv
module bypass_wdt_ctrl
  import bwd_pkg::*;
#(
  parameter int          EXP_W   = 4,
  parameter int          ADDR_W  = 2,
  parameter int          DATA_W  = 6,
  parameter logic [3:0]  RST_EXP = 4'd3,
  parameter logic [4:0]  NV_INIT = 5'h13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [1:0]        mode_o,
  output logic              relay_cross,
  output logic              host_iso,
  output logic              tx_cut,
  output logic              led_green,
  output logic              led_yellow
);
  localparam int EN_BIT   = EXP_W;
  localparam int FAIL_BIT = EXP_W + 1;

  logic             wr_mode, wr_wdt, wr_nv, wr_kick;
  logic [EXP_W-1:0] exp_q;
  logic             wdt_en_q;
  logic             fail_disc_q;
  logic [4:0]       nv_q = NV_INIT;
  logic             cap_byp, cap_disc, po_byp;
  logic [1:0]       pu_mode;
  logic             tmr_expire;
  logic [1:0]       mode_q;

  assign wr_mode = wr_en && (wr_addr == ADDR_W'(A_MODE));
  assign wr_wdt  = wr_en && (wr_addr == ADDR_W'(A_WDT));
  assign wr_nv   = wr_en && (wr_addr == ADDR_W'(A_NV));
  assign wr_kick = wr_en && (wr_addr == ADDR_W'(A_KICK));

  assign cap_byp  = nv_q[0];
  assign cap_disc = nv_q[1];
  assign pu_mode  = nv_q[3:2];
  assign po_byp   = nv_q[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q       <= RST_EXP[EXP_W-1:0];
      wdt_en_q    <= 1'b0;
      fail_disc_q <= 1'b0;
    end else if (wr_wdt) begin
      exp_q       <= wr_data[EXP_W-1:0];
      wdt_en_q    <= wr_data[EN_BIT];
      fail_disc_q <= wr_data[FAIL_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_nv) nv_q <= wr_data[4:0];
  end

  bwd_timer #(.EXP_W(EXP_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (wdt_en_q && pwr_good),
    .clear  (wr_kick || wr_wdt),
    .tick   (tick),
    .exp_p  (exp_q),
    .expire (tmr_expire)
  );

  bwd_mode u_mode (
    .clk       (clk),
    .rst       (rst),
    .pwr_good  (pwr_good),
    .cmd_valid (wr_mode),
    .cmd_mode  (wr_data[1:0]),
    .restore   (wr_kick && wr_data[0]),
    .expire    (tmr_expire),
    .fail_disc (fail_disc_q),
    .cap_byp   (cap_byp),
    .cap_disc  (cap_disc),
    .pu_mode   (pu_mode),
    .mode_q    (mode_q)
  );

  bwd_drive u_drive (
    .clk         (clk),
    .rst         (rst),
    .pwr_good    (pwr_good),
    .mode        (mode_q),
    .po_byp      (po_byp),
    .cap_byp     (cap_byp),
    .mode_o      (mode_o),
    .relay_cross (relay_cross),
    .host_iso    (host_iso),
    .tx_cut      (tx_cut),
    .led_green   (led_green),
    .led_yellow  (led_yellow)
  );
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker
  import bwd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       pwr_good,
  input logic       cap_byp,
  input logic       cap_disc,
  input logic       fail_disc,
  input logic       expire,
  input logic       wr_mode,
  input logic [1:0] mode_q,
  input logic [1:0] mode_o,
  input logic       relay_cross,
  input logic       tx_cut,
  input logic       led_green,
  input logic       led_yellow
);
  AST_LED_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(led_green && led_yellow)); // R3

  AST_CUT_NOT_CROSS: assert property (@(posedge clk) disable iff (rst)
    tx_cut |-> !relay_cross); // R4

  AST_NO_BYP_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!cap_byp && $past(!cap_byp)) |-> (mode_q != MD_BYPASS)); // R5

  AST_NO_DISC_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!cap_disc && $past(!cap_disc)) |-> (mode_q != MD_DISC)); // R6

  AST_EXPIRE_TO_BYP: assert property (@(posedge clk) disable iff (rst)
    (expire && !wr_mode && !fail_disc && cap_byp) |=> (mode_q == MD_BYPASS)); // R8

  AST_PWROFF_NO_DISC: assert property (@(posedge clk) disable iff (rst)
    (!pwr_good && $past(!pwr_good)) |=> (mode_o != MD_DISC)); // R12
endmodule

bind bypass_wdt_ctrl bwd_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .pwr_good    (pwr_good),
  .cap_byp     (cap_byp),
  .cap_disc    (cap_disc),
  .fail_disc   (fail_disc_q),
  .expire      (tmr_expire),
  .wr_mode     (wr_mode),
  .mode_q      (mode_q),
  .mode_o      (mode_o),
  .relay_cross (relay_cross),
  .tx_cut      (tx_cut),
  .led_green   (led_green),
  .led_yellow  (led_yellow)
);

// File: tb/tb_bypass_wdt_ctrl.sv
module tb_bypass_wdt_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_good = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic [1:0] mode_o;
  logic       relay_cross, host_iso, tx_cut, led_green, led_yellow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bypass_wdt_ctrl dut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_o(mode_o), .relay_cross(relay_cross), .host_iso(host_iso),
    .tx_cut(tx_cut), .led_green(led_green), .led_yellow(led_yellow)
  );

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // expected outputs: normal all low; bypass cross/iso/green; disconnect cut/yellow
  task automatic expect_mode(input string req, input logic [1:0] m);
    logic [6:0] act, exp;
    act = {mode_o, relay_cross, host_iso, tx_cut, led_green, led_yellow};
    exp = {m, m == 2'd1, m == 2'd1, m == 2'd2, m == 2'd1, m == 2'd2};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    expect_mode("R1 reset", 2'd0);

    wr(2'd0, 6'd1); settle(); expect_mode("R2 R3 cmd bypass", 2'd1);
    wr(2'd0, 6'd3); settle(); expect_mode("R2 code3 ignored", 2'd1);
    wr(2'd0, 6'd2); settle(); expect_mode("R2 R4 cmd disconnect", 2'd2);
    wr(2'd0, 6'd0); settle(); expect_mode("R2 R4 cmd normal", 2'd0);

    wr(2'd2, 6'h12); settle();
    wr(2'd0, 6'd1); settle(); expect_mode("R5 bypass cap off", 2'd0);
    wr(2'd0, 6'd2); settle(); expect_mode("R5 disconnect allowed", 2'd2);
    wr(2'd2, 6'h11); settle(); expect_mode("R6 cap removed", 2'd0);
    wr(2'd2, 6'h13); settle();

    for (int p = 0; p <= 4; p++) begin
      wr(2'd1, 6'(6'h10 | p));
      if (p > 0) ticks((1 << p) - 1);
      settle(); expect_mode("R7 before timeout", 2'd0);
      ticks(1);
      settle(); expect_mode("R7 R8 at timeout", 2'd1);
      wr(2'd3, 6'd1); settle(); expect_mode("R9 restore", 2'd0);
    end

    wr(2'd1, 6'h32); ticks(4); settle(); expect_mode("R8 fail disconnect", 2'd2);
    wr(2'd3, 6'd1); settle();

    wr(2'd1, 6'h12); ticks(4); settle();
    wr(2'd3, 6'd0); settle(); expect_mode("R9 hold on plain refresh", 2'd1);
    wr(2'd0, 6'd0); settle(); expect_mode("R9 mode write after expiry", 2'd0);

    wr(2'd1, 6'h13); ticks(5); wr(2'd3, 6'd0); ticks(7); settle();
    expect_mode("R10 refresh restart", 2'd0);
    ticks(1); settle(); expect_mode("R10 expiry after restart", 2'd1);
    wr(2'd3, 6'd1);

    wr(2'd1, 6'h13); ticks(6); wr(2'd1, 6'h12); ticks(3); settle();
    expect_mode("R11 reload on exponent write", 2'd0);
    ticks(1); settle(); expect_mode("R11 new timeout", 2'd1);
    wr(2'd3, 6'd1);

    wr(2'd1, 6'h03); ticks(20); settle(); expect_mode("R14 watchdog disabled", 2'd0);

    wr(2'd2, 6'h12); wr(2'd1, 6'h10); ticks(1); settle();
    expect_mode("R8 bypass cap off on expiry", 2'd0);
    wr(2'd2, 6'h11); wr(2'd1, 6'h30); ticks(1); settle();
    expect_mode("R8 disconnect cap off on expiry", 2'd0);
    wr(2'd1, 6'h00); wr(2'd2, 6'h13); settle();

    pwr_good = 1'b0; settle(); expect_mode("R12 power-off bypass", 2'd1);
    pwr_good = 1'b1; settle(); expect_mode("R13 power-up normal", 2'd0);
    wr(2'd2, 6'h03); pwr_good = 1'b0; settle(); expect_mode("R12 power-off normal", 2'd0);
    pwr_good = 1'b1;
    wr(2'd2, 6'h12); pwr_good = 1'b0; settle(); expect_mode("R12 bypass cap off", 2'd0);
    pwr_good = 1'b1;

    wr(2'd2, 6'h0B); pwr_good = 1'b0; settle(); pwr_good = 1'b1; settle();
    expect_mode("R13 power-up disconnect", 2'd2);
    wr(2'd0, 6'd0); settle();
    @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0; settle();
    expect_mode("R13 reset keeps retained default", 2'd2);
    wr(2'd2, 6'h09); pwr_good = 1'b0; settle(); pwr_good = 1'b1; settle();
    expect_mode("R13 power-up disconnect not allowed", 2'd0);
    wr(2'd2, 6'h07); pwr_good = 1'b0; settle(); pwr_good = 1'b1; settle();
    expect_mode("R13 power-up bypass", 2'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule